// File: doc/BRIEF.md
# Calibrated output code scaler

This block turns a signed raw result from a decimation filter into the final 16-bit output code. A two-step calibration stores its coefficients: a zero capture first records the raw value of the zero-scale input as the offset, then a full capture records the raw value of the full-scale input. From the span between the two captures, an iterative reciprocal divider derives a gain. The gain is an unsigned fixed-point value with 16 fractional bits, chosen so that the calibrated span maps to 2^16 code steps.

Every ordinary raw result is converted in three cycles. The stored offset is subtracted from the raw value, and the difference is multiplied by the gain. The product is then rounded, optionally shifted into offset-binary coding, and clamped to the 16-bit range. Unipolar and bipolar results use the same coefficients. The mode select is read only in the last pipeline cycle. Software can therefore change the mode after a result has entered the block, provided the select is stable before that result is published.

The controller has four states. `ST_IDLE` accepts input. It goes to `ST_SCALE` on an ordinary result, or to `ST_DIVIDE` on a valid full capture. `ST_SCALE` forms the product and always moves on to `ST_EMIT`. `ST_EMIT` forms and publishes the code, then returns to `ST_IDLE`. `ST_DIVIDE` waits for the divider and returns to `ST_IDLE` when the quotient is ready. A separate calibration phase register holds either `PH_WANT_ZERO` or `PH_WANT_FULL`. An accepted zero capture moves it from `PH_WANT_ZERO` to `PH_WANT_FULL`. An accepted full capture returns it to `PH_WANT_ZERO`.

Top module: `cal_code_scaler`

## Requirements
- R1: After reset, `code_out` is 0 and `code_valid` is 0. The offset is 0 and the gain is 1.0 (65536), so an unsigned-mode result equals the raw value before clamping.
- R2: Calibration order is fixed: a full capture is honoured only after a zero capture. A full capture given while a zero capture is still awaited changes no coefficient and produces no output.
- R3: A zero capture (`raw_valid` and `cal_zero` high) stores `raw_data` as the offset. A later full capture with span S = raw − offset > 0 sets the gain to floor(2^32 / S). When S = 1 the gain clamps to 2^32 − 1.
- R4: In unipolar mode (`bipolar_sel` = 0) the code is floor(((raw − offset)·gain + 2^15) / 2^16). This is straight binary, rounded to nearest with ties rounded up.
- R5: In bipolar mode (`bipolar_sel` = 1) the code is floor(((raw − offset)·gain + 2^16) / 2^17) + 0x8000. It uses the same stored coefficients with no recalibration, so a raw value equal to the offset gives 0x8000.
- R6: A result above the top of the code range is output as 0xFFFF in either mode.
- R7: A result below zero is output as 0x0000. In unipolar mode this means any raw value below the offset. In bipolar mode it means a raw value below negative full scale.
- R8: `bipolar_sel` is sampled only at the clock edge that publishes the result, two edges after `raw_valid` was taken. Its value at the accepting edge has no effect.
- R9: If `raw_valid` is taken at edge n, then `code_valid` is high for exactly one cycle, between edges n+2 and n+3, with the new `code_out`.
- R10: `raw_valid` is ignored while a conversion or a gain division is in progress. A full capture with span ≤ 0 leaves the gain unchanged and returns the phase to awaiting a zero capture.
- R11: Capture strobes never produce an output word. When `cal_zero` and `cal_full` are both high, the zero capture takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_valid | input | 1 | Raw result strobe |
| raw_data | input | RAW_W (24) | Signed raw filter result |
| cal_zero | input | 1 | With `raw_valid`: capture the zero reference |
| cal_full | input | 1 | With `raw_valid`: capture the full-scale reference |
| bipolar_sel | input | 1 | 1 = offset-binary, 0 = straight binary; read in the publish cycle |
| code_valid | output | 1 | One-cycle strobe for a new code |
| code_out | output | CODE_W (16) | Calibrated output code |

## Verification
Assertions check on every cycle that the output strobe lasts one cycle and follows the publish state. They also check that the gain changes only on the cycle after the divider finishes, and that the phase arms only on a zero capture. Further checks confirm that the divider remainder ends below the divisor, and that a result arriving during a division never starts a conversion. Only the bench scenarios can show the arithmetic itself: rounding, the bipolar bias, clamping at both ends, the late reading of the mode select, rejected spans and out-of-order captures. These are compared against codes the bench computes from the requirements.

// File: rtl/cal_code_scaler_pkg.sv
package cal_code_scaler_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCALE,
        ST_EMIT,
        ST_DIVIDE
    } scaler_state_e;

    typedef enum logic {
        PH_WANT_ZERO,
        PH_WANT_FULL
    } cal_phase_e;

endpackage

// File: rtl/recip_divider.sv
// Restoring long division of 2^(NUM_W-1) by a positive divisor, one quotient bit per cycle.
module recip_divider #(
    parameter int NUM_W = 33,
    parameter int DEN_W = 25,
    parameter int QUO_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [QUO_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEN_W-1:0] den_q;
    logic [DEN_W-1:0] rem_q;
    logic [NUM_W-1:0] num_q;
    logic [NUM_W-1:0] acc_q;

    logic [DEN_W:0] trial;
    logic           fits;
    logic [DEN_W:0] rem_next;

    always_comb begin
        trial    = {rem_q, num_q[NUM_W-1]};
        fits     = trial >= {1'b0, den_q};
        rem_next = fits ? (trial - {1'b0, den_q}) : trial;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            den_q  <= '0;
            rem_q  <= '0;
            num_q  <= '0;
            acc_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(NUM_W);
                den_q  <= den;
                rem_q  <= '0;
                num_q  <= {1'b1, {(NUM_W-1){1'b0}}};
                acc_q  <= '0;
            end else if (busy_q) begin
                rem_q <= rem_next[DEN_W-1:0];
                num_q <= num_q << 1;
                acc_q <= {acc_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    // Quotient wider than the gain register only for a divisor of one: clamp.
    assign quo = (|acc_q[NUM_W-1:QUO_W]) ? {QUO_W{1'b1}} : acc_q[QUO_W-1:0];

    // R3: a finished division leaves a remainder below the divisor
    assert_rem_below_den_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem_q < den_q));

endmodule

// File: rtl/code_shaper.sv
// Rounds the scaled product, applies the bipolar bias and clamps to the code range.
module code_shaper #(
    parameter int PROD_W = 58,
    parameter int FRAC_W = 16,
    parameter int CODE_W = 16
) (
    input  logic signed [PROD_W-1:0] prod,
    input  logic                     bipolar,
    output logic [CODE_W-1:0]        code
);
    localparam int EW = PROD_W + 2;
    localparam logic signed [EW-1:0] HALF_U   = EW'(1) <<< (FRAC_W - 1);
    localparam logic signed [EW-1:0] HALF_B   = EW'(1) <<< FRAC_W;
    localparam logic signed [EW-1:0] BIAS     = EW'(1) <<< (CODE_W - 1);
    localparam logic signed [EW-1:0] CODE_MAX = (EW'(1) <<< CODE_W) - EW'(1);

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] rnd_u;
    logic signed [EW-1:0] rnd_b;
    logic signed [EW-1:0] level;

    always_comb begin
        ext   = {{2{prod[PROD_W-1]}}, prod};
        rnd_u = (ext + HALF_U) >>> FRAC_W;
        rnd_b = ((ext + HALF_B) >>> (FRAC_W + 1)) + BIAS;
        level = bipolar ? rnd_b : rnd_u;
        if (level < 0) begin
            code = '0;
        end else if (level > CODE_MAX) begin
            code = '1;
        end else begin
            code = level[CODE_W-1:0];
        end
    end

    // R6/R7: clamped results sit exactly on the range ends
    always_comb begin
        if (level > CODE_MAX) assert_sat_high_R6: assert (code == '1);
        if (level < 0)        assert_sat_low_R7:  assert (code == '0);
    end

endmodule

// File: rtl/cal_code_scaler.sv
module cal_code_scaler
    import cal_code_scaler_pkg::*;
#(
    parameter int RAW_W  = 24,
    parameter int CODE_W = 16,
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_valid,
    input  logic [RAW_W-1:0]  raw_data,
    input  logic              cal_zero,
    input  logic              cal_full,
    input  logic              bipolar_sel,
    output logic              code_valid,
    output logic [CODE_W-1:0] code_out
);
    localparam int DIFF_W = RAW_W + 1;
    localparam int GAIN_W = CODE_W + FRAC_W;
    localparam int PROD_W = DIFF_W + GAIN_W + 1;
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << FRAC_W;

    scaler_state_e state_q, state_d;
    cal_phase_e    phase_q, phase_d;

    logic        [RAW_W-1:0]  offset_q;
    logic        [GAIN_W-1:0] gain_q;
    logic signed [DIFF_W-1:0] diff_q;
    logic signed [PROD_W-1:0] prod_q;

    logic signed [DIFF_W-1:0] diff_now;
    logic signed [PROD_W-1:0] prod_now;
    logic [CODE_W-1:0]        shaped;
    logic                     accept, take_zero, take_full, span_ok;
    logic                     div_start, start_conv, div_done;
    logic [GAIN_W-1:0]        div_quo;

    always_comb begin
        diff_now   = $signed({raw_data[RAW_W-1], raw_data}) - $signed({offset_q[RAW_W-1], offset_q});
        accept     = (state_q == ST_IDLE) && raw_valid;
        take_zero  = accept && cal_zero;
        take_full  = accept && !cal_zero && cal_full && (phase_q == PH_WANT_FULL);
        span_ok    = !diff_now[DIFF_W-1] && (|diff_now);
        div_start  = take_full && span_ok;
        start_conv = accept && !cal_zero && !cal_full;
        prod_now   = PROD_W'(diff_q) * $signed({{(PROD_W-GAIN_W){1'b0}}, gain_q});
    end

    recip_divider #(
        .NUM_W(GAIN_W + 1),
        .DEN_W(DIFF_W),
        .QUO_W(GAIN_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(div_start),
        .den  (diff_now),
        .done (div_done),
        .quo  (div_quo)
    );

    code_shaper #(
        .PROD_W(PROD_W),
        .FRAC_W(FRAC_W),
        .CODE_W(CODE_W)
    ) u_shape (
        .prod   (prod_q),
        .bipolar(bipolar_sel),
        .code   (shaped)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (div_start)       state_d = ST_DIVIDE;
                else if (start_conv) state_d = ST_SCALE;
            end
            ST_SCALE:  state_d = ST_EMIT;
            ST_EMIT:   state_d = ST_IDLE;
            ST_DIVIDE: if (div_done) state_d = ST_IDLE;
        endcase
        phase_d = phase_q;
        if (take_zero)      phase_d = PH_WANT_FULL;
        else if (take_full) phase_d = PH_WANT_ZERO;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_WANT_ZERO;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_q   <= '0;
            gain_q     <= UNITY;
            diff_q     <= '0;
            prod_q     <= '0;
            code_valid <= 1'b0;
            code_out   <= '0;
        end else begin
            code_valid <= 1'b0;
            if (take_zero)                          offset_q <= raw_data;
            if (state_q == ST_DIVIDE && div_done)   gain_q   <= div_quo;
            if (start_conv)                         diff_q   <= diff_now;
            if (state_q == ST_SCALE)                prod_q   <= prod_now;
            if (state_q == ST_EMIT) begin
                code_out   <= shaped;
                code_valid <= 1'b1;
            end
        end
    end

    // R9: one-cycle strobe
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> !code_valid);
    // R9: strobe only after the publish state
    assert_valid_after_emit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(state_q == ST_EMIT));
    // R3: gain moves only when the divider hands over its quotient
    assert_gain_from_divider_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_q) |-> $past(div_done && state_q == ST_DIVIDE));
    // R2: arming for the full capture needs a zero capture
    assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_q == PH_WANT_FULL) |-> $past(raw_valid && cal_zero));
    // R10: a result arriving during a division never starts a conversion
    assert_ignore_when_dividing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIVIDE && raw_valid) |=> (state_q != ST_SCALE));

endmodule

// File: tb/cal_code_scaler_test.sv
module cal_code_scaler_test;
    localparam int RAW_W  = 24;
    localparam int CODE_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              raw_valid = 1'b0;
    logic [RAW_W-1:0]  raw_data = '0;
    logic              cal_zero = 1'b0;
    logic              cal_full = 1'b0;
    logic              bipolar_sel = 1'b0;
    logic              code_valid;
    logic [CODE_W-1:0] code_out;

    int n_checks = 0;
    int n_fail   = 0;
    longint m_off  = 0;
    longint m_gain = 65536;

    always #4 clk = ~clk;

    cal_code_scaler #(.RAW_W(RAW_W), .CODE_W(CODE_W), .FRAC_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_data(raw_data),
        .cal_zero(cal_zero), .cal_full(cal_full), .bipolar_sel(bipolar_sel),
        .code_valid(code_valid), .code_out(code_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint exp_code(input longint raw, input bit bp);
        longint p, r;
        p = (raw - m_off) * m_gain;
        if (bp) r = ((p + 65536) >>> 17) + 32768;
        else    r = (p + 32768) >>> 16;
        if (r < 0)     r = 0;
        if (r > 65535) r = 65535;
        return r;
    endfunction

    // Convert one raw value; mode early at acceptance, late before the publish edge.
    task automatic conv(input int raw, input bit bp_early, input bit bp_late, input string req);
        longint e;
        e = exp_code(longint'(raw), bp_late);
        @(negedge clk);
        raw_valid = 1'b1; raw_data = RAW_W'(raw); bipolar_sel = bp_early;
        @(negedge clk);                 // edge n passed
        raw_valid = 1'b0;
        @(negedge clk);                 // edge n+1 passed
        bipolar_sel = bp_late;
        @(negedge clk);                 // edge n+2 passed: publish
        chk(code_valid == 1'b1, {req, " valid"}, code_valid, 1);
        chk(code_out == CODE_W'(e), req, code_out, e);
        @(negedge clk);
        chk(code_valid == 1'b0, "R9 strobe width", code_valid, 0);
    endtask

    task automatic pulse(input int raw, input bit z, input bit f, input bit extra_raw);
        @(negedge clk);
        raw_valid = 1'b1; raw_data = RAW_W'(raw); cal_zero = z; cal_full = f;
        @(negedge clk);
        cal_zero = 1'b0; cal_full = 1'b0;
        raw_valid = extra_raw;
    endtask

    // Full calibration sequence, updating the bench model.
    task automatic calibrate(input int zraw, input int fraw, input bit poke_busy);
        bit quiet;
        longint span;
        quiet = 1'b1;
        pulse(zraw, 1'b1, 1'b0, 1'b0);
        pulse(fraw, 1'b0, 1'b1, poke_busy);
        m_off = longint'(zraw);
        span  = longint'(fraw) - m_off;
        if (span > 0) begin
            m_gain = (64'sd1 <<< 32) / span;
            if (m_gain > 64'sh0FFFF_FFFF) m_gain = 64'sh0FFFF_FFFF;
        end
        for (int i = 0; i < 45; i++) begin
            @(negedge clk);
            raw_valid = 1'b0;
            if (code_valid) quiet = 1'b0;
        end
        chk(quiet, "R11 no output during calibration", !quiet, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit quiet;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(code_out == '0, "R1 reset code", code_out, 0);
        chk(code_valid == 1'b0, "R1 reset valid", code_valid, 0);

        conv(1234, 0, 0, "R1 unity gain");
        conv(-50, 0, 0, "R7 unipolar below zero");
        conv(1000, 1, 1, "R5 bipolar unity");
        conv(8388607, 0, 0, "R6 above range");

        calibrate(1000, 41000, 1'b0);
        conv(1000, 0, 0, "R4 zero point");
        conv(1000, 1, 1, "R5 zero gives 0x8000");
        conv(21000, 0, 0, "R4 mid scale");
        conv(41000, 0, 0, "R6 full scale clamps");
        conv(41000, 1, 1, "R6 bipolar full scale");
        conv(1000 - 45000, 1, 1, "R7 bipolar below -FS");
        conv(1000 + 13, 0, 0, "R4 rounding");
        conv(21000, 0, 1, "R8 late mode to bipolar");
        conv(21000, 1, 0, "R8 late mode to unipolar");

        // R2: full capture with no zero capture armed is ignored
        pulse(90000, 1'b0, 1'b1, 1'b0);
        repeat (45) @(negedge clk);
        conv(21000, 0, 0, "R2 full capture out of order");

        // R11: both strobes, zero wins, no output
        pulse(500, 1'b1, 1'b1, 1'b0);
        quiet = 1'b1;
        repeat (4) begin @(negedge clk); if (code_valid) quiet = 1'b0; end
        chk(quiet, "R11 strobes give no word", !quiet, 0);
        m_off = 500;
        pulse(500 + 30000, 1'b0, 1'b1, 1'b0);
        m_gain = (64'sd1 <<< 32) / 30000;
        repeat (45) @(negedge clk);
        conv(15500, 0, 0, "R11 zero priority then full");

        // R10: nonpositive span rejected, gain kept
        calibrate(5000, 4000, 1'b0);
        conv(20000, 0, 0, "R10 rejected span keeps gain");

        // R10: raw during divide ignored (checked as quiet calibration)
        calibrate(-2000, 60000, 1'b1);
        conv(30000, 0, 0, "R3 new gain after busy poke");

        // R3: span of one clamps the gain
        calibrate(100, 101, 1'b0);
        conv(100, 1, 1, "R3 clamped gain zero point");
        conv(99, 0, 0, "R3 clamped gain below");

        // R10: second raw during a conversion is ignored
        calibrate(0, 65536, 1'b0);
        @(negedge clk);
        raw_valid = 1'b1; raw_data = RAW_W'(777); bipolar_sel = 1'b0;
        @(negedge clk);
        raw_data = RAW_W'(9999);
        @(negedge clk);
        raw_valid = 1'b0;
        @(negedge clk);
        chk(code_valid && code_out == CODE_W'(exp_code(777, 0)), "R10 busy conversion", code_out, exp_code(777, 0));
        @(negedge clk);
        chk(!code_valid, "R10 no second word", code_valid, 0);
        @(negedge clk);
        chk(!code_valid, "R10 no late word", code_valid, 0);

        // Random calibrations and conversions
        for (int c = 0; c < 6; c++) begin
            int z, s;
            z = int'($urandom_range(0, 4194304)) - 2097152;
            s = int'($urandom_range(1000, 2097152));
            calibrate(z, z + s, 1'b0);
            for (int k = 0; k < 60; k++) begin
                int r;
                bit b;
                r = z - s + int'($urandom_range(0, 3 * s));
                b = 1'($urandom);
                conv(r, b, b, b ? "R5 random bipolar" : "R4 random unipolar");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule